// File: doc/BRIEF.md
# Parallel-Bus to LPC Host Bridge

This block is a Wishbone slave that turns each single Wishbone access into exactly one Low Pin Count bus cycle on the host side. It sends a start nibble with the frame strobe low. It then serialises a header built from the address, the cycle kind and, for writes, the data onto a 4-bit nibble bus that it can drive or release. After a two-clock turnaround it waits for the peripheral's SYNC response, collects read data, and finishes the Wishbone access with ack or err.

A 2-bit address tag picks one of four cycle families: port I/O, memory, DMA and firmware. For DMA and firmware cycles the byte-select pattern sets the transfer size to 1, 2 or 4 bytes. Port I/O and memory cycles always move one byte. DMA cycles also carry a 3-bit channel number and a terminal-count flag, taken from dedicated inputs when the access is accepted. A SYNC error code or a SYNC timeout aborts the bus cycle and is reported as a Wishbone error. Firmware cycles are the exception: they always end with a plain ack.

Top module: `lpc_host_bridge`

## Requirements
- R1: Tag encoding is 0 = port I/O, 1 = memory, 2 = DMA, 3 = firmware. Non-firmware cycles start with nibble 0000 followed by the nibble {tag, write, 0}. Firmware cycles start with 1110 for a write and 1101 for a read.
- R2: Address nibbles go out most significant first. Port I/O sends adr[15:0] as 4 nibbles and memory sends adr[31:0] as 8 nibbles. Firmware sends a 0000 device-select nibble, then adr[27:0] as 7 nibbles, then a size nibble.
- R3: For DMA and firmware, byte select 1111 means 4 bytes, 0011 means 2 bytes and 0001 means 1 byte. The DMA size nibble is 0011, 0001 or 0000 and the firmware size nibble is 0010, 0001 or 0000. Port I/O and memory move one byte whatever the byte select is.
- R4: A DMA cycle sends {terminal count, channel[2:0]} as one nibble, directly before its size nibble.
- R5: Write data follows the header, byte 0 (wb_dat_i[7:0]) first, each byte low nibble first. The bridge then drives 1111 for one clock and releases the bus.
- R6: The frame strobe is low only during the start nibble, and the nibble bus is driven whenever the strobe is low.
- R7: During SYNC, 0101 and 0110 mean wait and 0000 means ready. On a read, the 2×size nibbles that follow ready are returned on wb_dat_o, low byte first and low nibble first, with unfilled bytes zero.
- R8: A SYNC value of 1010 aborts the cycle: the strobe is held low with 1111 driven for exactly 4 clocks. The access then ends with err for port I/O, memory and DMA.
- R9: With no ready or error code, the cycle is aborted after SYNC_LIMIT clocks in SYNC and ends like R8. A ready in the last SYNC clock still completes normally.
- R10: Firmware cycles that fail through R8 or R9 end with ack and never with err.
- R11: Ack or err stays asserted while stb and cyc remain high, and clears one clock after either drops. Ack and err are never both high.
- R12: After reset the strobe is high, the nibble bus is released, and ack and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_adr | input | 32 | Wishbone address |
| wb_dat_i | input | 32 | Wishbone write data |
| wb_dat_o | output | 32 | Wishbone read data |
| wb_sel | input | 4 | Byte selects (transfer size) |
| wb_tga | input | 2 | Cycle kind tag |
| wb_we | input | 1 | Write enable |
| wb_stb | input | 1 | Strobe |
| wb_cyc | input | 1 | Cycle |
| wb_ack | output | 1 | Normal completion |
| wb_err | output | 1 | Failed completion |
| dma_chan | input | 3 | DMA channel for DMA cycles |
| dma_tc | input | 1 | DMA terminal count |
| lpc_frame_n | output | 1 | Frame strobe, active low |
| lpc_d_i | input | 4 | Nibble bus input |
| lpc_d_o | output | 4 | Nibble bus output |
| lpc_d_oe | output | 1 | Nibble bus drive enable |

## Verification
The assertions assume that the Wishbone master holds stb, cyc, address, tag, data and selects steady from request until ack or err. They also assume that only 0001, 0011 or 1111 appear as byte selects. The bench respects both: it changes Wishbone inputs only at a request or after a response, and it sweeps just those three select patterns. It also drives the nibble input only in the clocks where the bridge has released the bus, as a well-behaved peripheral would. That includes wait strings up to the timeout boundary and strings with no answer at all.

// File: rtl/lpc_bridge_pkg.sv
package lpc_bridge_pkg;

    typedef enum logic [1:0] {
        K_IO  = 2'd0,
        K_MEM = 2'd1,
        K_DMA = 2'd2,
        K_FW  = 2'd3
    } kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_TX, S_TARH, S_TARF, S_SYNC, S_RX, S_TARP, S_ABORT, S_RESP
    } st_e;

    localparam int TX_NIBS = 18;
    localparam int TXW     = TX_NIBS * 4;

    localparam logic [3:0] SY_READY = 4'b0000;
    localparam logic [3:0] SY_ERR   = 4'b1010;
    localparam logic [3:0] NIB_TAR  = 4'b1111;

    typedef struct packed {
        logic [TXW-1:0] nib;
        logic [4:0]     cnt;
    } tx_t;

    function automatic logic [2:0] xfer_bytes(kind_e k, logic [3:0] sel);
        if (k == K_IO || k == K_MEM) return 3'd1;
        if (sel == 4'b1111)          return 3'd4;
        if (sel[1])                  return 3'd2;
        return 3'd1;
    endfunction

    // Nibble 0 sits in bits [3:0] and is sent first.
    function automatic tx_t build_tx(kind_e k, logic we, logic [3:0] sel,
                                     logic [31:0] adr, logic [31:0] dat,
                                     logic [2:0] chan, logic tc);
        tx_t t;
        int n;
        int nb;
        t.nib = '0;
        n = 0;
        nb = int'(xfer_bytes(k, sel));
        if (k == K_FW) begin
            t.nib[n*4 +: 4] = we ? 4'b1110 : 4'b1101; n++;
            t.nib[n*4 +: 4] = 4'b0000;                n++;
            for (int i = 6; i >= 0; i--) begin
                t.nib[n*4 +: 4] = adr[i*4 +: 4]; n++;
            end
            t.nib[n*4 +: 4] = (nb == 4) ? 4'b0010 : (nb == 2) ? 4'b0001 : 4'b0000; n++;
        end else begin
            t.nib[n*4 +: 4] = 4'b0000;      n++;
            t.nib[n*4 +: 4] = {k, we, 1'b0}; n++;
            if (k == K_IO) begin
                for (int i = 3; i >= 0; i--) begin
                    t.nib[n*4 +: 4] = adr[i*4 +: 4]; n++;
                end
            end else if (k == K_MEM) begin
                for (int i = 7; i >= 0; i--) begin
                    t.nib[n*4 +: 4] = adr[i*4 +: 4]; n++;
                end
            end else begin
                t.nib[n*4 +: 4] = {tc, chan}; n++;
                t.nib[n*4 +: 4] = (nb == 4) ? 4'b0011 : (nb == 2) ? 4'b0001 : 4'b0000; n++;
            end
        end
        if (we) begin
            for (int b = 0; b < 4; b++) begin
                if (b < nb) begin
                    t.nib[n*4 +: 4] = dat[b*8 +: 4];     n++;
                    t.nib[n*4 +: 4] = dat[b*8 + 4 +: 4]; n++;
                end
            end
        end
        t.cnt = 5'(n);
        return t;
    endfunction

endpackage

// File: rtl/lpc_sync_watch.sv
module lpc_sync_watch
    import lpc_bridge_pkg::*;
#(
    parameter int SYNC_LIMIT = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic [3:0] nib,
    output logic       ready,
    output logic       fail
);
    localparam int CW = $clog2(SYNC_LIMIT + 1);

    logic [CW-1:0] cnt;
    logic          err_code;
    logic          expired;

    always_ff @(posedge clk) begin
        if (rst || !active) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign ready    = active && (nib == SY_READY);
    assign err_code = active && (nib == SY_ERR);
    assign expired  = active && (cnt == CW'(SYNC_LIMIT - 1));
    assign fail     = err_code || (expired && !ready);

    // R9
    sync_window_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < CW'(SYNC_LIMIT)));

endmodule

// File: rtl/lpc_rx_gather.sv
module lpc_rx_gather (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [3:0]  nib,
    output logic [31:0] data
);
    logic [2:0] idx;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            data <= '0;
            idx  <= '0;
        end else if (en) begin
            data[idx*4 +: 4] <= nib;
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/lpc_host_bridge.sv
module lpc_host_bridge
    import lpc_bridge_pkg::*;
#(
    parameter int SYNC_LIMIT = 64,
    parameter int ABORT_CLKS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] wb_adr,
    input  logic [31:0] wb_dat_i,
    output logic [31:0] wb_dat_o,
    input  logic [3:0]  wb_sel,
    input  logic [1:0]  wb_tga,
    input  logic        wb_we,
    input  logic        wb_stb,
    input  logic        wb_cyc,
    output logic        wb_ack,
    output logic        wb_err,
    input  logic [2:0]  dma_chan,
    input  logic        dma_tc,
    output logic        lpc_frame_n,
    input  logic [3:0]  lpc_d_i,
    output logic [3:0]  lpc_d_o,
    output logic        lpc_d_oe
);
    st_e            st;
    logic [TXW-1:0] tx_sh;
    logic [4:0]     cnt;
    logic [2:0]     nbytes;
    logic           first, rd, fw, fail_r;
    logic           req, sy_ready, sy_fail;
    tx_t            next_tx;

    assign req = wb_stb && wb_cyc;

    always_comb next_tx = build_tx(kind_e'(wb_tga), wb_we, wb_sel, wb_adr,
                                   wb_dat_i, dma_chan, dma_tc);

    lpc_sync_watch #(.SYNC_LIMIT(SYNC_LIMIT)) u_sync (
        .clk(clk), .rst(rst), .active(st == S_SYNC), .nib(lpc_d_i),
        .ready(sy_ready), .fail(sy_fail)
    );

    lpc_rx_gather u_rx (
        .clk(clk), .rst(rst), .clr(st == S_IDLE), .en(st == S_RX),
        .nib(lpc_d_i), .data(wb_dat_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            tx_sh  <= '0;
            cnt    <= '0;
            nbytes <= '0;
            first  <= 1'b0;
            rd     <= 1'b0;
            fw     <= 1'b0;
            fail_r <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (req) begin
                    tx_sh  <= next_tx.nib;
                    cnt    <= next_tx.cnt;
                    nbytes <= xfer_bytes(kind_e'(wb_tga), wb_sel);
                    first  <= 1'b1;
                    rd     <= !wb_we;
                    fw     <= (wb_tga == K_FW);
                    fail_r <= 1'b0;
                    st     <= S_TX;
                end
                S_TX: begin
                    tx_sh <= tx_sh >> 4;
                    first <= 1'b0;
                    cnt   <= cnt - 1'b1;
                    if (cnt == 5'd1) st <= S_TARH;
                end
                S_TARH: st <= S_TARF;
                S_TARF: st <= S_SYNC;
                S_SYNC: begin
                    if (sy_fail) begin
                        fail_r <= 1'b1;
                        cnt    <= 5'(ABORT_CLKS);
                        st     <= S_ABORT;
                    end else if (sy_ready) begin
                        if (rd) begin
                            cnt <= {1'b0, nbytes, 1'b0};
                            st  <= S_RX;
                        end else begin
                            cnt <= 5'd2;
                            st  <= S_TARP;
                        end
                    end
                end
                S_RX: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == 5'd1) begin
                        cnt <= 5'd2;
                        st  <= S_TARP;
                    end
                end
                S_TARP, S_ABORT: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == 5'd1) st <= S_RESP;
                end
                S_RESP: if (!req) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign lpc_d_o     = (st == S_TX) ? tx_sh[3:0] : NIB_TAR;
    assign lpc_d_oe    = (st == S_TX) || (st == S_TARH) || (st == S_ABORT);
    assign lpc_frame_n = !((st == S_TX && first) || st == S_ABORT);
    assign wb_ack      = (st == S_RESP) && !(fail_r && !fw);
    assign wb_err      = (st == S_RESP) && fail_r && !fw;

    // R11
    resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((wb_ack || wb_err) && req) |=> (wb_ack || wb_err));
    // R11
    resp_release_chk: assert property (@(posedge clk) disable iff (rst)
        ((wb_ack || wb_err) && !req) |=> !(wb_ack || wb_err));
    // R11
    resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wb_ack && wb_err));
    // R10
    fw_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        fw |-> !wb_err);
    // R6
    frame_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !lpc_frame_n |-> lpc_d_oe);
    // R7
    sync_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_SYNC || st == S_RX) |-> !lpc_d_oe);

endmodule

// File: tb/test_lpc_host_bridge.sv
module test_lpc_host_bridge;

    localparam int LIMIT = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] wb_adr = '0, wb_dat_i = '0;
    logic [31:0] wb_dat_o;
    logic [3:0]  wb_sel = '0;
    logic [1:0]  wb_tga = '0;
    logic        wb_we = 1'b0, wb_stb = 1'b0, wb_cyc = 1'b0;
    logic        wb_ack, wb_err;
    logic [2:0]  dma_chan = '0;
    logic        dma_tc = 1'b0;
    logic        lpc_frame_n;
    logic [3:0]  lpc_d_i = 4'hF;
    logic [3:0]  lpc_d_o;
    logic        lpc_d_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [3:0] exp_n [0:31];
    int ne;

    always #5 clk = ~clk;

    lpc_host_bridge #(.SYNC_LIMIT(LIMIT), .ABORT_CLKS(4)) i_lpc_host_bridge (
        .clk(clk), .rst(rst), .wb_adr(wb_adr), .wb_dat_i(wb_dat_i),
        .wb_dat_o(wb_dat_o), .wb_sel(wb_sel), .wb_tga(wb_tga), .wb_we(wb_we),
        .wb_stb(wb_stb), .wb_cyc(wb_cyc), .wb_ack(wb_ack), .wb_err(wb_err),
        .dma_chan(dma_chan), .dma_tc(dma_tc), .lpc_frame_n(lpc_frame_n),
        .lpc_d_i(lpc_d_i), .lpc_d_o(lpc_d_o), .lpc_d_oe(lpc_d_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic int nbytes_of(input int kind, input logic [3:0] sel);
        if (kind < 2) return 1;
        if (sel == 4'hF) return 4;
        if (sel == 4'h3) return 2;
        return 1;
    endfunction

    task automatic push(input logic [3:0] v);
        exp_n[ne] = v;
        ne++;
    endtask

    task automatic expect_nibs(input int kind, input bit we, input logic [3:0] sel,
                               input logic [31:0] adr, input logic [31:0] dat,
                               input logic [2:0] chan, input bit tc);
        int nb;
        nb = nbytes_of(kind, sel);
        ne = 0;
        if (kind == 3) begin
            push(we ? 4'hE : 4'hD);
            push(4'h0);
            for (int i = 6; i >= 0; i--) push(adr[i*4 +: 4]);
            push(nb == 4 ? 4'h2 : nb == 2 ? 4'h1 : 4'h0);
        end else begin
            push(4'h0);
            push(4'(kind * 4 + (we ? 2 : 0)));
            if (kind == 0) for (int i = 3; i >= 0; i--) push(adr[i*4 +: 4]);
            if (kind == 1) for (int i = 7; i >= 0; i--) push(adr[i*4 +: 4]);
            if (kind == 2) begin
                push({tc, chan});
                push(nb == 4 ? 4'h3 : nb == 2 ? 4'h1 : 4'h0);
            end
        end
        if (we) for (int b = 0; b < nb; b++) begin
            push(dat[b*8 +: 4]);
            push(dat[b*8 + 4 +: 4]);
        end
        push(4'hF);
    endtask

    // mode: 0 ready, 1 error code, 2 no answer (timeout)
    task automatic access(input int kind, input bit we, input logic [3:0] sel,
                          input logic [31:0] adr, input logic [31:0] dat,
                          input logic [2:0] chan, input bit tc, input int nwait,
                          input int mode, input logic [31:0] rdata);
        int k, mism, fbad, g, ab, nb, cyc;
        bit experr;
        logic [31:0] mask;
        string hdr_tag;
        nb = nbytes_of(kind, sel);
        expect_nibs(kind, we, sel, adr, dat, chan, tc);
        hdr_tag = (kind == 2) ? "R1 R3 R4 R5" : (kind == 3) ? "R1 R2 R3 R5" : "R1 R2 R5";
        @(negedge clk);
        wb_tga = 2'(kind); wb_we = we; wb_sel = sel; wb_adr = adr; wb_dat_i = dat;
        dma_chan = chan; dma_tc = tc; wb_stb = 1'b1; wb_cyc = 1'b1;
        g = 0;
        do begin @(negedge clk); g++; end while (!lpc_d_oe && g < 20);
        k = 0; mism = 0; fbad = 0;
        while (lpc_d_oe && k < 40) begin
            if (k >= ne || lpc_d_o !== exp_n[k]) mism++;
            if (lpc_frame_n !== (k != 0)) fbad++;
            @(negedge clk);
            k++;
        end
        chk(mism == 0 && k == ne, hdr_tag, 32'(k), 32'(ne));
        chk(fbad == 0, "R6 frame low only at start", 32'(fbad), 0);
        lpc_d_i = 4'hF;
        if (mode == 2) begin
            cyc = 0;
            while (lpc_frame_n && cyc < 200) begin @(negedge clk); cyc++; end
            chk(cyc == LIMIT + 1, "R9 timeout clock", 32'(cyc), 32'(LIMIT + 1));
        end else begin
            @(negedge clk);
            for (int w = 0; w < nwait; w++) begin
                lpc_d_i = (w % 2 == 1) ? 4'b0110 : 4'b0101;
                @(negedge clk);
            end
            lpc_d_i = (mode == 1) ? 4'b1010 : 4'b0000;
            @(negedge clk);
            if (mode == 0 && !we) begin
                for (int i = 0; i < 2 * nb; i++) begin
                    lpc_d_i = rdata[i*4 +: 4];
                    @(negedge clk);
                end
            end
            lpc_d_i = 4'hF;
        end
        ab = 0; g = 0;
        while (!(wb_ack || wb_err) && g < 40) begin
            if (!lpc_frame_n) begin
                ab++;
                if (lpc_d_o !== 4'hF || !lpc_d_oe) ab += 100;
            end
            @(negedge clk);
            g++;
        end
        chk(ab == (mode != 0 ? 4 : 0), "R8 abort strobe length", 32'(ab),
            32'(mode != 0 ? 4 : 0));
        experr = (mode != 0) && (kind != 3);
        if (kind == 3 && mode != 0)
            chk(wb_ack && !wb_err, "R10 firmware fail acks", {30'd0, wb_ack, wb_err}, 32'h2);
        else
            chk(wb_ack == !experr && wb_err == experr, mode == 2 ? "R9 err on timeout" :
                mode == 1 ? "R8 err on abort" : "R7 ack after ready",
                {30'd0, wb_ack, wb_err}, {30'd0, !experr, experr});
        if (mode == 0 && !we) begin
            mask = (nb == 4) ? 32'hFFFF_FFFF : (nb == 2) ? 32'h0000_FFFF : 32'h0000_00FF;
            chk(wb_dat_o === (rdata & mask), "R7 read data", wb_dat_o, rdata & mask);
        end
        @(negedge clk); @(negedge clk);
        chk((wb_ack || wb_err) === 1'b1, "R11 response held", {31'd0, wb_ack | wb_err}, 1);
        wb_stb = 1'b0; wb_cyc = 1'b0;
        @(negedge clk);
        chk(!wb_ack && !wb_err, "R11 response released", {30'd0, wb_ack, wb_err}, 0);
    endtask

    initial begin
        logic [3:0] sels [0:2];
        sels[0] = 4'h1; sels[1] = 4'h3; sels[2] = 4'hF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(lpc_frame_n && !lpc_d_oe && !wb_ack && !wb_err, "R12 reset state",
            {28'd0, lpc_frame_n, lpc_d_oe, wb_ack, wb_err}, 32'h8);
        for (int kind = 0; kind < 4; kind++)
            for (int we = 0; we < 2; we++)
                for (int s = 0; s < 3; s++)
                    access(kind, we[0], sels[s],
                           32'h9A3C_5E71 + 32'(kind) * 32'h1357_2468 + 32'(s) * 32'h0F0F_1111,
                           32'hC3A5_1E2D ^ (32'(kind * 3 + s) * 32'h0101_0101),
                           3'(kind + s * 3), s[0], (kind + s) % 3, 0,
                           32'h8765_4321 + 32'(kind * 7 + s) * 32'h1111_1111);
        for (int kind = 0; kind < 4; kind++)
            for (int we = 0; we < 2; we++)
                access(kind, we[0], 4'hF, 32'h0000_0008, 32'h1234_5678, 3'd2, 1'b0, 1, 1, 0);
        access(0, 1'b0, 4'h1, 32'h0000_03F8, 0, 0, 1'b0, 0, 2, 0);
        access(3, 1'b1, 4'h3, 32'h0FFF_FFF0, 32'h0000_ABCD, 0, 1'b0, 0, 2, 0);
        access(1, 1'b0, 4'h1, 32'hFEDC_BA98, 0, 0, 1'b0, LIMIT - 1, 0, 32'h0000_005A);
        access(2, 1'b0, 4'hF, 32'h0, 0, 3'd7, 1'b1, LIMIT - 1, 0, 32'hDEAD_BEEF);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule